// File: doc/BRIEF.md
# Trap Entry State Sequencer

This block computes the processor state that results when a trap is taken on a 64-bit core with windowed registers. A one-cycle `trap_valid` strobe brings in a 9-bit trap type together with a snapshot of the current program counters, condition codes, address-space identifier, processor-state word, current window pointer, the count of windows that can still be saved, and the trap base address. One clock later the block presents the new trap level, program counters, processor-state word, window pointer and trap base register, and raises `update_done` for a single cycle.

The trap level and the per-level trap stack are held inside the block. Each accepted trap writes one stack entry, selected by the new level. An entry holds a packed saved-state word, the interrupted PC and NPC, and the trap type. A combinational read port lets the surrounding core, or a bench, inspect any level. If a trap arrives when the level has already reached its maximum, the block flags the error state and leaves every register untouched.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset the trap level, every state output and every trap-stack entry read as zero, and `update_done` and `error_state` are low.
- R2: A trap accepted at level L sets the level to L+1 one clock after `trap_valid`. If L is MAXTL-1 or higher, the new processor-state word also has the RED bit (bit 5) set.
- R3: A trap presented while the level equals MAXTL raises `error_state` for one cycle. `update_done` stays low, and the level, all state outputs and all trap-stack entries keep their values.
- R4: The accepted trap writes the saved-state word at stack level L+1, with every other bit zero: CCR in bits 39:32, ASI in bits 31:24, the incoming PSTATE ANDed with 0xF3F in bits 19:8, and the incoming window pointer in the low bits.
- R5: The same stack entry stores the incoming PC, the incoming NPC and the 9-bit trap type.
- R6: The new PSTATE always has PEF (bit 4) and PRIV (bit 2) set, plus exactly one globals select. Trap type 0x060 selects interrupt globals (bit 11). Types 0x008 and 0x030, and 0x064 through 0x06F, select MMU globals (bit 10). Every other type selects alternate globals (bit 0).
- R7: Type 0x024 sets the window pointer to CWP-1. Types 0x080 to 0x0BF set it to CWP-CANSAVE-2. Types 0x0C0 to 0x0FF set it to CWP+1. All other types pass CWP through unchanged. All of this arithmetic is modulo NWIN.
- R8: The new trap base register keeps bits 63:15 of the base input. Bit 14 is set when the new level exceeds 1, bits 13:5 hold the trap type, and bits 4:0 are zero. The new PC equals this value.
- R9: The new NPC equals the new PC plus 4. `update_done` is high only in the cycle after an accepted `trap_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | One-cycle trap request |
| trap_type | input | 9 | Trap type code |
| pc_in | input | 64 | PC at the trap |
| npc_in | input | 64 | NPC at the trap |
| ccr_in | input | 8 | Condition codes |
| asi_in | input | 8 | Address-space identifier |
| pstate_in | input | 12 | Processor-state word |
| cwp_in | input | 3 | Current window pointer |
| cansave_in | input | 3 | Windows that can be saved |
| tba_in | input | 64 | Trap base address |
| rd_level | input | 3 | Trap-stack level to read (1..MAXTL) |
| rd_state | output | 40 | Saved-state word at rd_level |
| rd_pc | output | 64 | Saved PC at rd_level |
| rd_npc | output | 64 | Saved NPC at rd_level |
| rd_tt | output | 9 | Saved trap type at rd_level |
| tl_out | output | 3 | Current trap level |
| pc_out | output | 64 | New PC |
| npc_out | output | 64 | New NPC |
| pstate_out | output | 12 | New processor-state word |
| cwp_out | output | 3 | New window pointer |
| tbr_out | output | 64 | New trap base register |
| update_done | output | 1 | New state valid strobe |
| error_state | output | 1 | Trap taken at maximum level |

## Verification
The assertions check several properties on every cycle. The level steps by exactly one on each completed update. An error cycle never coincides with an update and only occurs at the maximum level. The vector carries the trap type in its low field. NPC trails PC by 4. Exactly one globals select is set. Stack writes never target level zero.

Only the bench scenarios can show the exact data values. These include the trap-class decode across all 512 trap types, the modular window arithmetic for every CWP and CANSAVE pair, the packing of the saved-state word, the RED bit on the last legal level, and the fact that a trap at the maximum level leaves the earlier stack entries intact.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  localparam int TT_W     = 9;
  localparam int PS_W     = 12;
  localparam int TSTATE_W = 40;

  // processor-state bit positions
  localparam int PS_AG   = 0;
  localparam int PS_PRIV = 2;
  localparam int PS_PEF  = 4;
  localparam int PS_RED  = 5;
  localparam int PS_MG   = 10;
  localparam int PS_IG   = 11;
  localparam logic [PS_W-1:0] PS_SAVE_MASK = 12'hF3F;

  // trap type codes the sequencer decodes
  localparam logic [TT_W-1:0] TT_INT_VEC  = 9'h060;
  localparam logic [TT_W-1:0] TT_IFAULT   = 9'h008;
  localparam logic [TT_W-1:0] TT_DAFAULT  = 9'h030;
  localparam logic [TT_W-1:0] TT_IMISS    = 9'h064;
  localparam logic [TT_W-1:0] TT_DMISS4   = 9'h068;
  localparam logic [TT_W-1:0] TT_DPROT4   = 9'h06C;
  localparam logic [TT_W-1:0] TT_CLEANWIN = 9'h024;
  localparam logic [TT_W-1:0] WIN_GRP_MSK = 9'h1C0;
  localparam logic [TT_W-1:0] WIN_SPILL   = 9'h080;
  localparam logic [TT_W-1:0] WIN_FILL    = 9'h0C0;

  typedef enum logic [1:0] {GSEL_ALT, GSEL_MMU, GSEL_INT} gsel_e;
  typedef enum logic [1:0] {WADJ_NONE, WADJ_CLEAN, WADJ_SPILL, WADJ_FILL} wadj_e;

  function automatic gsel_e classify_globals(input logic [TT_W-1:0] tt);
    if (tt == TT_INT_VEC) return GSEL_INT;
    if (tt == TT_IFAULT || tt == TT_DAFAULT ||
        tt[TT_W-1:2] == TT_IMISS[TT_W-1:2] ||
        tt[TT_W-1:2] == TT_DMISS4[TT_W-1:2] ||
        tt[TT_W-1:2] == TT_DPROT4[TT_W-1:2]) return GSEL_MMU;
    return GSEL_ALT;
  endfunction

  function automatic wadj_e classify_window(input logic [TT_W-1:0] tt);
    if (tt == TT_CLEANWIN) return WADJ_CLEAN;
    if ((tt & WIN_GRP_MSK) == WIN_SPILL) return WADJ_SPILL;
    if ((tt & WIN_GRP_MSK) == WIN_FILL) return WADJ_FILL;
    return WADJ_NONE;
  endfunction

  function automatic logic [PS_W-1:0] entry_pstate(input gsel_e g, input logic red);
    logic [PS_W-1:0] p;
    p = '0;
    p[PS_PEF]  = 1'b1;
    p[PS_PRIV] = 1'b1;
    p[PS_RED]  = red;
    case (g)
      GSEL_INT: p[PS_IG] = 1'b1;
      GSEL_MMU: p[PS_MG] = 1'b1;
      default:  p[PS_AG] = 1'b1;
    endcase
    return p;
  endfunction

  function automatic logic [TSTATE_W-1:0] pack_tstate(input logic [7:0] ccr,
      input logic [7:0] asi, input logic [PS_W-1:0] ps, input logic [7:0] cwp8);
    return {ccr, asi, 4'b0000, ps & PS_SAVE_MASK, cwp8};
  endfunction
endpackage

// File: rtl/trap_window_adj.sv
module trap_window_adj
  import trap_seq_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CWPW = $clog2(NWIN)
) (
  input  logic [TT_W-1:0] tt,
  input  logic [CWPW-1:0] cwp,
  input  logic [CWPW-1:0] cansave,
  output logic [CWPW-1:0] cwp_new
);
  wadj_e kind;
  int    base;

  always_comb begin
    kind = classify_window(tt);
    base = int'(cwp);
    case (kind)
      WADJ_CLEAN: cwp_new = CWPW'((base + NWIN - 1) % NWIN);
      WADJ_SPILL: cwp_new = CWPW'((base + 2 * NWIN - int'(cansave) - 2) % NWIN);
      WADJ_FILL:  cwp_new = CWPW'((base + 1) % NWIN);
      default:    cwp_new = cwp;
    endcase
  end
endmodule

// File: rtl/trap_stack.sv
module trap_stack
  import trap_seq_pkg::*;
#(
  parameter int DEPTH  = 5,
  parameter int ADDR_W = 64,
  parameter int TLW    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [TLW-1:0]      wr_level,
  input  logic [TSTATE_W-1:0] wr_state,
  input  logic [ADDR_W-1:0]   wr_pc,
  input  logic [ADDR_W-1:0]   wr_npc,
  input  logic [TT_W-1:0]     wr_tt,
  input  logic [TLW-1:0]      rd_level,
  output logic [TSTATE_W-1:0] rd_state,
  output logic [ADDR_W-1:0]   rd_pc,
  output logic [ADDR_W-1:0]   rd_npc,
  output logic [TT_W-1:0]     rd_tt
);
  logic [TSTATE_W-1:0] st_q  [DEPTH];
  logic [ADDR_W-1:0]   pc_q  [DEPTH];
  logic [ADDR_W-1:0]   npc_q [DEPTH];
  logic [TT_W-1:0]     tt_q  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]  <= '0;
        pc_q[g]  <= '0;
        npc_q[g] <= '0;
        tt_q[g]  <= '0;
      end else if (wr_en && wr_level == TLW'(g + 1)) begin
        st_q[g]  <= wr_state;
        pc_q[g]  <= wr_pc;
        npc_q[g] <= wr_npc;
        tt_q[g]  <= wr_tt;
      end
    end
  end

  always_comb begin
    rd_state = '0;
    rd_pc    = '0;
    rd_npc   = '0;
    rd_tt    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_level == TLW'(i + 1)) begin
        rd_state = st_q[i];
        rd_pc    = pc_q[i];
        rd_npc   = npc_q[i];
        rd_tt    = tt_q[i];
      end
    end
  end

  // R4: a write always targets a real level
  assert_wr_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_level != '0 && int'(wr_level) <= DEPTH));
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_seq_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int MAXTL  = 5,
  parameter int ADDR_W = 64,
  localparam int CWPW  = $clog2(NWIN),
  localparam int TLW   = $clog2(MAXTL + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trap_valid,
  input  logic [TT_W-1:0]     trap_type,
  input  logic [ADDR_W-1:0]   pc_in,
  input  logic [ADDR_W-1:0]   npc_in,
  input  logic [7:0]          ccr_in,
  input  logic [7:0]          asi_in,
  input  logic [PS_W-1:0]     pstate_in,
  input  logic [CWPW-1:0]     cwp_in,
  input  logic [CWPW-1:0]     cansave_in,
  input  logic [ADDR_W-1:0]   tba_in,
  input  logic [TLW-1:0]      rd_level,
  output logic [TSTATE_W-1:0] rd_state,
  output logic [ADDR_W-1:0]   rd_pc,
  output logic [ADDR_W-1:0]   rd_npc,
  output logic [TT_W-1:0]     rd_tt,
  output logic [TLW-1:0]      tl_out,
  output logic [ADDR_W-1:0]   pc_out,
  output logic [ADDR_W-1:0]   npc_out,
  output logic [PS_W-1:0]     pstate_out,
  output logic [CWPW-1:0]     cwp_out,
  output logic [ADDR_W-1:0]   tbr_out,
  output logic                update_done,
  output logic                error_state
);
  localparam logic [TLW-1:0] TL_MAX  = TLW'(MAXTL);
  localparam logic [TLW-1:0] TL_REDL = TLW'(MAXTL - 1);

  // named internal events
  logic                accept_w, err_hit_w, red_hit_w, nested_w;
  logic [TLW-1:0]      tl_next_w;
  logic [CWPW-1:0]     cwp_next_w;
  logic [PS_W-1:0]     ps_next_w;
  logic [ADDR_W-1:0]   vec_w;
  logic [TSTATE_W-1:0] tstate_w;

  logic [TLW-1:0]    tl_q;
  logic [ADDR_W-1:0] pc_q, npc_q, tbr_q;
  logic [PS_W-1:0]   ps_q;
  logic [CWPW-1:0]   cwp_q;
  logic              done_q, err_q;

  assign accept_w  = trap_valid && (tl_q < TL_MAX);
  assign err_hit_w = trap_valid && !(tl_q < TL_MAX);
  assign red_hit_w = tl_q >= TL_REDL;
  assign tl_next_w = tl_q + TLW'(1);
  assign nested_w  = tl_next_w > TLW'(1);
  assign ps_next_w = entry_pstate(classify_globals(trap_type), red_hit_w);
  assign vec_w     = {tba_in[ADDR_W-1:15], nested_w, trap_type, 5'b00000};
  assign tstate_w  = pack_tstate(ccr_in, asi_in, pstate_in, 8'(cwp_in));

  trap_window_adj #(.NWIN(NWIN)) u_wadj (
    .tt      (trap_type),
    .cwp     (cwp_in),
    .cansave (cansave_in),
    .cwp_new (cwp_next_w)
  );

  trap_stack #(.DEPTH(MAXTL), .ADDR_W(ADDR_W), .TLW(TLW)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (accept_w),
    .wr_level (tl_next_w),
    .wr_state (tstate_w),
    .wr_pc    (pc_in),
    .wr_npc   (npc_in),
    .wr_tt    (trap_type),
    .rd_level (rd_level),
    .rd_state (rd_state),
    .rd_pc    (rd_pc),
    .rd_npc   (rd_npc),
    .rd_tt    (rd_tt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tl_q   <= '0;
      pc_q   <= '0;
      npc_q  <= '0;
      tbr_q  <= '0;
      ps_q   <= '0;
      cwp_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= accept_w;
      err_q  <= err_hit_w;
      if (accept_w) begin
        tl_q  <= tl_next_w;
        tbr_q <= vec_w;
        pc_q  <= vec_w;
        npc_q <= vec_w + ADDR_W'(4);
        ps_q  <= ps_next_w;
        cwp_q <= cwp_next_w;
      end
    end
  end

  assign tl_out      = tl_q;
  assign pc_out      = pc_q;
  assign npc_out     = npc_q;
  assign tbr_out     = tbr_q;
  assign pstate_out  = ps_q;
  assign cwp_out     = cwp_q;
  assign update_done = done_q;
  assign error_state = err_q;

  assert_level_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    update_done |-> tl_q == $past(tl_q) + TLW'(1));
  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tl_q <= TL_MAX);
  assert_err_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    error_state |-> (!update_done && tl_q == TL_MAX));
  assert_err_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    error_state |-> ($stable(pc_q) && $stable(ps_q) && $stable(cwp_q)));
  assert_one_globals_R6: assert property (@(posedge clk) disable iff (!rst_n)
    update_done |-> ($countones({ps_q[PS_IG], ps_q[PS_MG], ps_q[PS_AG]}) == 1
                     && ps_q[PS_PEF] && ps_q[PS_PRIV]));
  assert_vector_tt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    update_done |-> (pc_q[4:0] == 5'b0 && pc_q[13:5] == $past(trap_type)));
  assert_npc_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    update_done |-> npc_q == pc_q + ADDR_W'(4));
  assert_done_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    update_done |-> $past(trap_valid));
endmodule

// File: tb/sim_trap_entry_seq.sv
module sim_trap_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        trap_valid;
  logic [8:0]  trap_type;
  logic [63:0] pc_in, npc_in, tba_in;
  logic [7:0]  ccr_in, asi_in;
  logic [11:0] pstate_in;
  logic [2:0]  cwp_in, cansave_in, rd_level;
  logic [39:0] rd_state;
  logic [63:0] rd_pc, rd_npc, pc_out, npc_out, tbr_out;
  logic [8:0]  rd_tt;
  logic [2:0]  tl_out, cwp_out;
  logic [11:0] pstate_out;
  logic        update_done, error_state;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  trap_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_type(trap_type),
    .pc_in(pc_in), .npc_in(npc_in), .ccr_in(ccr_in), .asi_in(asi_in),
    .pstate_in(pstate_in), .cwp_in(cwp_in), .cansave_in(cansave_in),
    .tba_in(tba_in), .rd_level(rd_level), .rd_state(rd_state), .rd_pc(rd_pc),
    .rd_npc(rd_npc), .rd_tt(rd_tt), .tl_out(tl_out), .pc_out(pc_out),
    .npc_out(npc_out), .pstate_out(pstate_out), .cwp_out(cwp_out),
    .tbr_out(tbr_out), .update_done(update_done), .error_state(error_state)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; trap_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive a trap for one cycle; returns at the next negedge with outputs updated
  task automatic do_trap(input logic [8:0] tt, input logic [63:0] pc,
      input logic [7:0] ccr, input logic [7:0] asi, input logic [11:0] ps,
      input logic [2:0] cwp, input logic [2:0] cs);
    trap_type = tt; pc_in = pc; npc_in = pc + 64'd4; ccr_in = ccr;
    asi_in = asi; pstate_in = ps; cwp_in = cwp; cansave_in = cs;
    trap_valid = 1'b1;
    @(negedge clk);
    trap_valid = 1'b0;
  endtask

  function automatic logic [11:0] model_ps(input logic [8:0] tt, input bit red);
    logic [11:0] g;
    if (tt == 9'h060) g = 12'h800;
    else if (tt == 9'h008 || tt == 9'h030 || (tt >= 9'h064 && tt <= 9'h06F)) g = 12'h400;
    else g = 12'h001;
    return g | 12'h014 | (red ? 12'h020 : 12'h000);
  endfunction

  function automatic logic [2:0] model_cwp(input logic [8:0] tt,
      input logic [2:0] c, input logic [2:0] s);
    if (tt == 9'h024) return c - 3'd1;
    if (tt >= 9'h080 && tt <= 9'h0BF) return c - s - 3'd2;
    if (tt >= 9'h0C0 && tt <= 9'h0FF) return c + 3'd1;
    return c;
  endfunction

  function automatic logic [63:0] model_vec(input logic [63:0] tba,
      input logic [8:0] tt, input int new_tl);
    return (tba & ~64'h7FFF) | ((new_tl > 1) ? 64'h4000 : 64'h0) | (64'(tt) << 5);
  endfunction

  initial begin : watchdog
    #600000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [63:0] save_pc;
    logic [11:0] save_ps;
    rst_n = 1'b0; trap_valid = 1'b0; trap_type = '0; pc_in = '0; npc_in = '0;
    ccr_in = '0; asi_in = '0; pstate_in = '0; cwp_in = '0; cansave_in = '0;
    tba_in = 64'hFFFF_0000_1234_C000; rd_level = 3'd1;
    do_reset();

    // R1: reset state
    chk("R1", "tl", 64'(tl_out), 64'd0);
    chk("R1", "pc", pc_out, 64'd0);
    chk("R1", "done", 64'(update_done), 64'd0);
    chk("R1", "err", 64'(error_state), 64'd0);
    chk("R1", "stack state", 64'(rd_state), 64'd0);

    // sweep every trap type as a first-level trap
    for (int t = 0; t < 512; t++) begin
      logic [63:0] pcv;
      logic [11:0] psv;
      logic [2:0]  cw, cs;
      pcv = {32'hA5A5_0000, 23'd0, 9'(t)} << 2;
      psv = 12'(t * 37 + 5);
      cw  = 3'(t);
      cs  = 3'(t >> 3);
      do_reset();
      do_trap(9'(t), pcv, 8'(t + 1), 8'(t ^ 8'h5A), psv, cw, cs);
      rd_level = 3'd1;
      #1;
      chk("R2", "tl", 64'(tl_out), 64'd1);
      chk("R9", "done", 64'(update_done), 64'd1);
      chk("R4", "tstate", 64'(rd_state),
          {24'd0, 8'(t + 1), 8'(t ^ 8'h5A), 4'd0, psv & 12'hF3F, 5'd0, cw});
      chk("R5", "tpc", rd_pc, pcv);
      chk("R5", "tnpc", rd_npc, pcv + 64'd4);
      chk("R5", "tt", 64'(rd_tt), 64'(t));
      chk("R6", "pstate", 64'(pstate_out), 64'(model_ps(9'(t), 1'b0)));
      chk("R7", "cwp", 64'(cwp_out), 64'(model_cwp(9'(t), cw, cs)));
      chk("R8", "tbr", tbr_out, model_vec(tba_in, 9'(t), 1));
      chk("R8", "pc", pc_out, model_vec(tba_in, 9'(t), 1));
      chk("R9", "npc", npc_out, model_vec(tba_in, 9'(t), 1) + 64'd4);
      @(negedge clk);
      chk("R9", "done drops", 64'(update_done), 64'd0);
    end

    // R7: full window arithmetic over cwp and cansave for each window class
    for (int c = 0; c < 8; c++) begin
      for (int s = 0; s < 8; s++) begin
        do_reset();
        do_trap(9'h080 + 9'(s * 4), 64'h100, 8'h0, 8'h0, 12'h0, 3'(c), 3'(s));
        chk("R7", "spill cwp", 64'(cwp_out), 64'((c - s - 2 + 16) % 8));
        do_reset();
        do_trap(9'h0C4, 64'h100, 8'h0, 8'h0, 12'h0, 3'(c), 3'(s));
        chk("R7", "fill cwp", 64'(cwp_out), 64'((c + 1) % 8));
        do_reset();
        do_trap(9'h024, 64'h100, 8'h0, 8'h0, 12'h0, 3'(c), 3'(s));
        chk("R7", "clean cwp", 64'(cwp_out), 64'((c + 7) % 8));
      end
    end

    // nesting chain up to the maximum level, then the error state
    do_reset();
    for (int l = 1; l <= 5; l++) begin
      do_trap(9'h041 + 9'(l), 64'h2000 + 64'(l * 16), 8'(l), 8'(l), 12'h0FF, 3'd2, 3'd1);
      chk("R2", "nested tl", 64'(tl_out), 64'(l));
      chk("R2", "red bit", 64'(pstate_out[5]), 64'(l == 5));
      chk("R8", "nested vec", pc_out, model_vec(tba_in, 9'h041 + 9'(l), l));
    end
    save_pc = pc_out;
    save_ps = pstate_out;
    do_trap(9'h010, 64'hDEAD_0000, 8'hFF, 8'hFF, 12'hFFF, 3'd7, 3'd7);
    chk("R3", "err", 64'(error_state), 64'd1);
    chk("R3", "no done", 64'(update_done), 64'd0);
    chk("R3", "tl hold", 64'(tl_out), 64'd5);
    chk("R3", "pc hold", pc_out, save_pc);
    chk("R3", "ps hold", 64'(pstate_out), 64'(save_ps));
    for (int l = 1; l <= 5; l++) begin
      rd_level = 3'(l);
      #1;
      chk("R3", "stack pc intact", rd_pc, 64'h2000 + 64'(l * 16));
      chk("R5", "stack tt intact", 64'(rd_tt), 64'(9'h041 + 9'(l)));
    end
    @(negedge clk);
    chk("R3", "err pulse", 64'(error_state), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule